// File: doc/BRIEF.md
# Per-Processor Interrupt Interface

This block sits between an interrupt distributor and one processor. The distributor presents its single best pending candidate as an ID and an 8-bit priority. The block decides whether that candidate may be signalled to the processor, and drives one registered interrupt request line when it may. The decision takes into account the interface enable, a priority mask and the priority of the interrupt already being serviced.

Software talks to the block through a small register port. It sets an enable bit, a priority mask and a binary point. It reads an acknowledge register to take the signalled interrupt and writes the same ID to an end-of-interrupt register when the handler is done. Taken interrupts are held in an 8-entry active stack. The top of that stack gives the running priority. A new candidate preempts only if its group priority is strictly below the running one. The group priority keeps only the bits that the binary point selects. When an interrupt is taken, the block pulses `take_o` with its ID so that the distributor can clear the pending state.

Top module: `icpu_top`

## Requirements
- R1: After reset `irq_o` is low and the control (address 0), priority mask (address 1) and binary point (address 2) registers all read zero.
- R2: When control bit 0 (enable) is clear, `irq_o` stays low and the acknowledge register returns 1023, whatever candidate is presented.
- R3: A candidate can be signalled only if its priority is numerically lower than the priority mask value in bits 7:0 of address 1. A candidate whose priority equals the mask is not signalled.
- R4: A read of address 3 (acknowledge) while a candidate can be signalled returns the candidate ID in bits 9:0. In the same cycle it pulses `take_o` with that ID and pushes the candidate onto the active stack.
- R5: A read of address 3 while nothing can be signalled returns 1023. It changes no state and does not pulse `take_o`.
- R6: `irq_o` rises one clock after a candidate becomes signalable. It is low in the cycle after the acknowledge read that takes the interrupt.
- R7: While interrupts are active, a candidate is signalled only if `prio & M` is strictly below `run & M`. Here `run` is the running priority (0xFF when idle) and M keeps priority bits 7 down to n+1, with n the binary point in bits 2:0 of address 2.
- R8: A binary point of 7 disables nesting: nothing is signalled while any interrupt is active.
- R9: A write to address 4 (end of interrupt) with an active ID in bits 9:0 removes that entry from the active stack. The running priority then falls back to the remaining top entry, or to idle.
- R10: A write to address 4 with an ID that matches no active entry is ignored.
- R11: The active stack holds 8 entries. When it is full, no candidate is signalled and an acknowledge read returns 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cand_valid_i | input | 1 | Distributor candidate present |
| cand_id_i | input | 10 | Candidate interrupt ID (below 1020) |
| cand_prio_i | input | 8 | Candidate priority, lower is more urgent |
| reg_req_i | input | 1 | Register access strobe, one access per cycle |
| reg_we_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| irq_o | output | 1 | Registered interrupt request to the processor |
| take_o | output | 1 | Pulse: candidate taken by an acknowledge read |
| take_id_o | output | 10 | ID of the taken candidate |

## Verification
The assertions check on every cycle the rules that hold at any moment. With enable clear, the request line goes low on the next clock. Every take is below the mask, comes from a stack that is not full, returns the taken ID and grows the stack by one. A take under binary point 7 happens only from an idle stack. The request drops after a take, and a spurious read never takes. The bench scenarios are needed for the rest: the group comparison at particular binary points, where the same candidate is signalled at one setting and blocked at another; the recovery of running priority after an end-of-interrupt; the unmatched end-of-interrupt that leaves priority unchanged; and the exact cycle on which the request line rises.

// File: rtl/icpu_pkg.sv
package icpu_pkg;
  localparam int ID_W   = 10;
  localparam int PRIO_W = 8;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 3'd0,
    REG_PMASK  = 3'd1,
    REG_BPOINT = 3'd2,
    REG_ACK    = 3'd3,
    REG_EOI    = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/icpu_cfg_regs.sv
module icpu_cfg_regs
  import icpu_pkg::*;
#(
  parameter int PRIO_W_P = PRIO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [PRIO_W_P-1:0] wdata_i,
  output logic              en_o,
  output logic [PRIO_W_P-1:0] pmask_o,
  output logic [2:0]        bpoint_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o     <= 1'b0;
      pmask_o  <= '0;
      bpoint_o <= '0;
    end else if (wr_i) begin
      case (addr_i)
        REG_CTRL:   en_o     <= wdata_i[0];
        REG_PMASK:  pmask_o  <= wdata_i;
        REG_BPOINT: bpoint_o <= wdata_i[2:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/icpu_active_stack.sv
module icpu_active_stack #(
  parameter int DEPTH  = 8,
  parameter int ID_W   = 10,
  parameter int PRIO_W = 8,
  localparam int DW    = $clog2(DEPTH + 1),
  localparam int IW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic [ID_W-1:0]   push_id_i,
  input  logic [PRIO_W-1:0] push_prio_i,
  input  logic              eoi_i,
  input  logic [ID_W-1:0]   eoi_id_i,
  output logic [DW-1:0]     depth_o,
  output logic              empty_o,
  output logic              full_o,
  output logic [PRIO_W-1:0] run_prio_o
);
  logic [ID_W-1:0]   id_q [DEPTH];
  logic [PRIO_W-1:0] pr_q [DEPTH];
  logic [DW-1:0]     depth_q;
  logic [DEPTH-1:0]  match;
  logic [IW-1:0]     pos;
  logic              hit;

  for (genvar g = 0; g < DEPTH; g++) begin : g_match
    assign match[g] = (DW'(g) < depth_q) && (id_q[g] == eoi_id_i);
  end

  // topmost matching entry is removed
  always_comb begin
    pos = '0;
    for (int i = 0; i < DEPTH; i++) if (match[i]) pos = IW'(i);
  end
  assign hit = |match;

  always_comb begin
    run_prio_o = '1;
    for (int i = 0; i < DEPTH; i++) if (DW'(i + 1) == depth_q) run_prio_o = pr_q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        id_q[i] <= '0;
        pr_q[i] <= '1;
      end
    end else if (push_i && !full_o) begin
      for (int i = 0; i < DEPTH; i++) begin
        if (DW'(i) == depth_q) begin
          id_q[i] <= push_id_i;
          pr_q[i] <= push_prio_i;
        end
      end
      depth_q <= depth_q + DW'(1);
    end else if (eoi_i && hit) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IW'(i) >= pos) begin
          id_q[i] <= id_q[i+1];
          pr_q[i] <= pr_q[i+1];
        end
      end
      depth_q <= depth_q - DW'(1);
    end
  end

  assign depth_o = depth_q;
  assign empty_o = (depth_q == '0);
  assign full_o  = (depth_q == DW'(DEPTH));
endmodule

// File: rtl/icpu_select.sv
module icpu_select #(
  parameter int PRIO_W = 8
) (
  input  logic              en_i,
  input  logic              cand_valid_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic [PRIO_W-1:0] pmask_i,
  input  logic [2:0]        bpoint_i,
  input  logic              empty_i,
  input  logic              full_i,
  input  logic [PRIO_W-1:0] run_prio_i,
  output logic              signal_o
);
  logic [3:0]        shamt;
  logic [PRIO_W-1:0] grp_mask;
  logic              no_nest;
  logic              preempt_ok;

  assign shamt    = {1'b0, bpoint_i} + 4'd1;
  assign grp_mask = {PRIO_W{1'b1}} << shamt;
  assign no_nest  = (bpoint_i == 3'd7);

  assign preempt_ok = empty_i ||
                      (!no_nest && !full_i &&
                       ((cand_prio_i & grp_mask) < (run_prio_i & grp_mask)));

  assign signal_o = en_i && cand_valid_i && (cand_prio_i < pmask_i) && preempt_ok;
endmodule

// File: rtl/icpu_top.sv
module icpu_top
  import icpu_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cand_valid_i,
  input  logic [ID_W-1:0]   cand_id_i,
  input  logic [PRIO_W-1:0] cand_prio_i,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              take_o,
  output logic [ID_W-1:0]   take_id_o
);
  logic              en;
  logic [PRIO_W-1:0] pmask;
  logic [2:0]        bpoint;
  logic [DW-1:0]     depth;
  logic              empty, full;
  logic [PRIO_W-1:0] run_prio;
  logic              signal;
  logic              ack_rd, eoi_wr, cfg_wr;
  logic              irq_q;
  logic              unused_wdata;

  assign unused_wdata = ^reg_wdata_i[DATA_W-1:ID_W];

  assign cfg_wr = reg_req_i && reg_we_i;
  assign ack_rd = reg_req_i && !reg_we_i && (reg_addr_i == REG_ACK);
  assign eoi_wr = reg_req_i && reg_we_i && (reg_addr_i == REG_EOI);

  icpu_cfg_regs #(.PRIO_W_P(PRIO_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (cfg_wr),
    .addr_i   (reg_addr_i),
    .wdata_i  (reg_wdata_i[PRIO_W-1:0]),
    .en_o     (en),
    .pmask_o  (pmask),
    .bpoint_o (bpoint)
  );

  icpu_select #(.PRIO_W(PRIO_W)) u_sel (
    .en_i         (en),
    .cand_valid_i (cand_valid_i),
    .cand_prio_i  (cand_prio_i),
    .pmask_i      (pmask),
    .bpoint_i     (bpoint),
    .empty_i      (empty),
    .full_i       (full),
    .run_prio_i   (run_prio),
    .signal_o     (signal)
  );

  assign take_o    = ack_rd && signal;
  assign take_id_o = cand_id_i;

  icpu_active_stack #(.DEPTH(DEPTH), .ID_W(ID_W), .PRIO_W(PRIO_W)) u_stk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (take_o),
    .push_id_i   (cand_id_i),
    .push_prio_i (cand_prio_i),
    .eoi_i       (eoi_wr),
    .eoi_id_i    (reg_wdata_i[ID_W-1:0]),
    .depth_o     (depth),
    .empty_o     (empty),
    .full_o      (full),
    .run_prio_o  (run_prio)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      REG_CTRL:   reg_rdata_o = DATA_W'(en);
      REG_PMASK:  reg_rdata_o = DATA_W'(pmask);
      REG_BPOINT: reg_rdata_o = DATA_W'(bpoint);
      REG_ACK:    reg_rdata_o = DATA_W'(signal ? cand_id_i : SPURIOUS_ID);
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= signal && !take_o;
  end
  assign irq_o = irq_q;
endmodule

// File: rtl/icpu_checker.sv
module icpu_checker
  import icpu_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int DW   = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              irq_o,
  input logic              take_o,
  input logic [ID_W-1:0]   take_id_o,
  input logic              en,
  input logic [PRIO_W-1:0] pmask,
  input logic [2:0]        bpoint,
  input logic [PRIO_W-1:0] cand_prio_i,
  input logic [DW-1:0]     depth,
  input logic              full,
  input logic              reg_req_i,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0] reg_rdata_o
);
  logic ack_rd;
  assign ack_rd = reg_req_i && !reg_we_i && (reg_addr_i == REG_ACK);

  p_irq_needs_enable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !irq_o);

  p_take_below_mask_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (cand_prio_i < pmask));

  p_take_returns_id_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |-> (reg_rdata_o[ID_W-1:0] == take_id_o));

  p_take_pushes_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> (depth == $past(depth) + DW'(1)));

  p_spurious_no_take_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rd && reg_rdata_o[ID_W-1:0] == SPURIOUS_ID) |-> !take_o);

  p_irq_drops_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_o |=> !irq_o);

  p_no_nest_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && bpoint == 3'd7) |-> (depth == '0));

  p_full_blocks_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full |-> !take_o);

  p_depth_bound_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth <= DW'(DEPTH));
endmodule

bind icpu_top icpu_checker #(.DEPTH(DEPTH)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .irq_o       (irq_o),
  .take_o      (take_o),
  .take_id_o   (take_id_o),
  .en          (en),
  .pmask       (pmask),
  .bpoint      (bpoint),
  .cand_prio_i (cand_prio_i),
  .depth       (depth),
  .full        (full),
  .reg_req_i   (reg_req_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o)
);

// File: tb/sim_icpu_top.sv
`timescale 1ns/1ps
module sim_icpu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cand_valid = 1'b0;
  logic [9:0]  cand_id = '0;
  logic [7:0]  cand_prio = 8'hFF;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, take;
  logic [9:0]  take_id;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  icpu_top u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .cand_valid_i(cand_valid), .cand_id_i(cand_id), .cand_prio_i(cand_prio),
    .reg_req_i(req), .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .take_o(take), .take_id_o(take_id)
  );

  // monitor: read data is compared in the middle of the read cycle
  always @(negedge clk) begin
    if (req && !we && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        failures++;
        $display("FAIL %s rdata actual=%0d expected=%0d", t, rdata, e);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    step(); req = 1; we = 1; addr = a; wdata = d;
    step(); req = 0; we = 0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string t);
    step(); req = 1; we = 0; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    step(); req = 0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(posedge clk); #2;
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s irq actual=%0b expected=%0b", t, irq, e);
    end
  endtask

  task automatic chk_irq_now(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      failures++;
      $display("FAIL %s irq actual=%0b expected=%0b", t, irq, e);
    end
  endtask

  task automatic cand(input logic v, input logic [9:0] id, input logic [7:0] p);
    cand_valid = v; cand_id = id; cand_prio = p;
  endtask

  // take: acknowledge read, then the distributor model withdraws the candidate
  task automatic take_one(input logic [9:0] id, input string t);
    step(); req = 1; we = 0; addr = 3'd3;
    exp_q.push_back(32'(id)); tag_q.push_back(t);
    step(); req = 0; cand_valid = 0;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    chk_irq_now(1'b0, "R1 irq after reset");
    rd(3'd0, 0, "R1 ctrl reset");
    rd(3'd1, 0, "R1 pmask reset");
    rd(3'd2, 0, "R1 bpoint reset");
    rd(3'd3, 1023, "R5 ack with nothing");

    // R3 mask of zero blocks all
    cand(1, 10'd40, 8'h80);
    wr(3'd0, 1);
    chk_irq(1'b0, "R3 pmask zero blocks");
    wr(3'd0, 0);
    wr(3'd1, 32'hF0);
    chk_irq(1'b0, "R2 disabled no irq");
    rd(3'd3, 1023, "R2 disabled ack spurious");
    wr(3'd0, 1);
    chk_irq(1'b1, "R6 irq rises");
    wr(3'd1, 32'h80);
    chk_irq(1'b0, "R3 equal to mask blocked");
    wr(3'd1, 32'h81);
    chk_irq(1'b1, "R3 below mask signalled");

    // R4 take, R6 drop
    take_one(10'd40, "R4 ack returns id 40");
    chk_irq_now(1'b0, "R6 irq low after take");
    rd(3'd3, 1023, "R5 ack after take spurious");
    wr(3'd3, 0); // write to ack address has no effect
    wr(3'd1, 32'hFF);

    // R7 group compare, running 0x80, bpoint 0
    cand(1, 10'd50, 8'h81);
    chk_irq(1'b0, "R7 lower urgency no preempt");
    cand(1, 10'd60, 8'h7F);
    chk_irq(1'b1, "R7 higher urgency preempts");
    wr(3'd2, 7);
    chk_irq(1'b0, "R8 bpoint 7 no nesting");
    rd(3'd3, 1023, "R8 ack spurious when nesting off");
    wr(3'd2, 0);
    chk_irq(1'b1, "R7 preempt restored");
    take_one(10'd60, "R4 ack returns id 60");

    // running 0x7F now
    cand(1, 10'd70, 8'h70);
    wr(3'd2, 3);
    chk_irq(1'b0, "R7 bpoint 3 same group");
    wr(3'd2, 2);
    chk_irq(1'b1, "R7 bpoint 2 finer group");
    wr(3'd2, 3);
    chk_irq(1'b0, "R7 back to bpoint 3");

    // R10 unmatched eoi ignored
    wr(3'd4, 99);
    chk_irq(1'b0, "R10 unmatched eoi ignored");
    // R9 eoi of top restores 0x80
    wr(3'd4, 60);
    chk_irq(1'b1, "R9 running priority falls back");
    wr(3'd4, 40);
    chk_irq(1'b1, "R9 idle after last eoi");
    take_one(10'd70, "R4 ack returns id 70");
    wr(3'd4, 70);

    // R11 fill the stack
    wr(3'd2, 0);
    for (int k = 0; k < 8; k++) begin
      cand(1, 10'(100 + k), 8'(8'hF0 - 16 * k));
      chk_irq(1'b1, "R11 nesting level signalled");
      take_one(10'(100 + k), "R11 nested ack");
    end
    cand(1, 10'd200, 8'h00);
    chk_irq(1'b0, "R11 full stack blocks");
    rd(3'd3, 1023, "R11 ack spurious when full");
    wr(3'd4, 107);
    chk_irq(1'b1, "R9 eoi frees a slot");
    take_one(10'd200, "R4 ack returns id 200");
    chk_irq_now(1'b0, "R6 irq low after final take");

    repeat (2) step();
    if (exp_q.size() != 0) begin
      checks++;
      failures++;
      $display("FAIL monitor queue not drained actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule